// File: doc/BRIEF.md
# Parallel display bus engine

This block turns a 32-bit register interface into an 8080-style parallel panel bus. The host fills a byte FIFO with word, halfword or byte writes. After the host sets the transfer length and clears its chip-select bit, the engine cuts the buffered bytes into 8-bit or 16-bit beats. For every beat it pulses a write strobe. The strobe's low phase and the idle phase that follows are both counted in bus ticks, and a bus tick is the core clock divided by a programmable factor from 1 to 8. A command/data select line and an active-low chip select travel with the beats.

The direction can be turned around. In the read direction the engine pulses a read strobe, captures the panel's data on the tick that ends the strobe, and queues those bytes in the same FIFO for the host to collect. A status bit tells software that the FIFO has drained and that no beat is in flight. An identification register returns an alternating bit pattern after it is armed, so that software can check the register path.

Top module: `pdisp_bus_engine`

Register offsets (byte address on `reg_addr`): 0x00 ident, 0x04 timing/transfer, 0x08 control/status, 0x0C bus format, 0x10 FIFO port. `reg_size` gives the access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.

## Requirements
- R1: After reset, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1. The timing register reads 0x43000000 (chip-select bit 30 = 1, rest field 3). The control register reads 0x18 (write-hold bit 4 = 1, drained bit 3 = 1). The format register reads 0x67 (width-1 = 7, beats-1 = 3, divider-1 = 0).
- R2: Writing 0 to the ident register makes the next ident read return 0x55555555 and the read after that return 0xAAAAAAAA. Later reads return {major[15:0], minor[15:0]}, which is 0x00020001 by default.
- R3: A bus tick lasts D+1 clocks, where D is format bits 12:10. Each strobe stays low for exactly (A+1) ticks, where A is timing bits 23:20.
- R4: Within one transfer, when bytes are ready the strobe stays high for exactly (R+1) ticks between two beats, where R is timing bits 29:24.
- R5: When format bits 4:0 equal 15, each beat is 16 bits and `bus_dout` = {second byte, first byte}. For any other value, each beat is 8 bits, with the byte on `bus_dout[7:0]` and bits 15:8 at 0. `bus_dout` holds still while the strobe is low.
- R6: FIFO-port writes of 1, 2 or 4 bytes append their bytes in little-endian order.
- R7: A transfer issues exactly (timing bits 17:0) + 1 beats and then stops by itself, even if bytes remain in the FIFO.
- R8: `bus_dc` follows timing bit 18 (0 = command, 1 = data).
- R9: `bus_cs_n` = timing bit 30 OR NOT control bit 0 (enable). A write that clears bit 30 loads the beat count and starts the transfer. A strobe never falls while `bus_cs_n` is high.
- R10: Control bit 3 reads 1 exactly when the FIFO is empty and no beat is in progress.
- R11: When control bit 5 = 1 (read direction), the engine pulses `bus_rd_n` and captures `bus_din` on the tick where the strobe rises. Host reads of the FIFO port return the captured bytes little-endian, with missing bytes read as 0.
- R12: While timing bits 29:24 hold a value below 2, or control bit 1 (soft reset) is 1, the engine is held in reset and the FIFO is emptied. The flushed bytes are never sent.
- R13: Write strobes need control bit 5 = 0 and control bit 4 = 0. Read strobes need bit 5 = 1. `bus_oe` is high only in the write direction with chip select active. `bus_wr_n` and `bus_rd_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_dc | output | 1 | Command (0) / data (1) select |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_dout | output | 16 | Beat data toward the panel |
| bus_din | input | 16 | Data from the panel |

## Verification
The bench times every strobe edge in clocks and compares it with (A+1)(D+1) and (R+1)(D+1), so an off-by-one in either tick counter or the divider shows up as a wrong width or gap. Beat contents come from host writes of mixed sizes. A byte-order swap, or a wrong pick of byte versus halfword, appears as a wrong `bus_dout` value. A transfer that stops one beat late or early shows up in the beat count, with bytes deliberately left over in the FIFO.

The flush cases check that bytes cleared by the short-rest self reset, or by the soft reset, are never sent afterwards. The read test checks captured data against what was driven during each strobe, so a capture on the wrong tick returns a stale or future pattern.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

  typedef enum logic [1:0] {ENG_IDLE, ENG_ACT, ENG_REST} eng_state_e;
  typedef enum logic [1:0] {ID_VER, ID_FIRST, ID_SECOND} id_state_e;

  localparam logic [4:0] OFS_IDENT = 5'h00;
  localparam logic [4:0] OFS_TIMING = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_FORMAT = 5'h0C;
  localparam logic [4:0] OFS_PORT = 5'h10;

  localparam logic [31:0] ID_PAT_A = 32'h5555_5555;
  localparam logic [31:0] ID_PAT_B = 32'hAAAA_AAAA;

  // Bytes carried by one host access of the given size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Bytes carried by one bus beat.
  function automatic logic [2:0] beat_bytes(input logic wide);
    return wide ? 3'd2 : 3'd1;
  endfunction

  // A rest phase shorter than three ticks is not allowed.
  function automatic logic rest_too_short(input logic [5:0] rest_m1);
    return rest_m1 < 6'd2;
  endfunction

  // Keeps the first n bytes of a word and zeroes the rest.
  function automatic logic [31:0] byte_mask(input logic [2:0] n);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/pdisp_tick_div.sv
module pdisp_tick_div #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_m1,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = (cnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R3: a divided tick is a single-clock pulse
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0 && $stable(div_m1)) |=> !tick);

endmodule

// File: rtl/pdisp_byte_fifo.sv
module pdisp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic [2:0]    pop_n,
  output logic [31:0]   peek,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (i < int'(push_n)) mem[wptr + AW'(i)] <= push_data[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < 4; i++) peek[8*i +: 8] = mem[rptr + AW'(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      wptr  <= wptr + AW'(push_n);
      rptr  <= rptr + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  a_r6_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);

endmodule

// File: rtl/pdisp_beat_engine.sv
module pdisp_beat_engine
  import pdisp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1,
  parameter int NW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic [NW-1:0] load_cnt,
  input  logic          rd_dir,
  input  logic          wr_allow,
  input  logic          wide,
  input  logic [3:0]    act_m1,
  input  logic [5:0]    rest_m1,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [15:0]   fifo_peek,
  input  logic [15:0]   bus_din,
  output logic [2:0]    pop_n,
  output logic [2:0]    push_n,
  output logic [15:0]   push_data,
  output logic          wr_n,
  output logic          rd_n,
  output logic [15:0]   dout,
  output logic          busy,
  output logic          beat_start,
  output logic          beat_end
);
  eng_state_e    st;
  logic [3:0]    act_cnt;
  logic [5:0]    rest_cnt;
  logic [NW-1:0] remain;
  logic          is_rd;
  logic [2:0]    bpb;
  logic          ready, slot;

  assign bpb   = beat_bytes(wide);
  assign ready = rd_dir ? ((CW'(DEPTH) - fifo_cnt) >= CW'(bpb))
                        : (wr_allow && fifo_cnt >= CW'(bpb));
  assign slot  = tick && (st == ENG_IDLE || (st == ENG_REST && rest_cnt == '0));
  assign beat_start = !flush && run && slot && remain != '0 && ready;
  assign beat_end   = !flush && run && tick && st == ENG_ACT && act_cnt == '0;
  assign pop_n      = (beat_start && !rd_dir) ? bpb : 3'd0;
  assign push_n     = (beat_end && is_rd) ? bpb : 3'd0;
  assign push_data  = wide ? bus_din : {8'h00, bus_din[7:0]};
  assign busy       = (st != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; act_cnt <= '0; rest_cnt <= '0; remain <= '0;
      is_rd <= 1'b0; wr_n <= 1'b1; rd_n <= 1'b1; dout <= '0;
    end else if (flush) begin
      st <= ENG_IDLE; remain <= '0; wr_n <= 1'b1; rd_n <= 1'b1;
    end else begin
      if (load) remain <= load_cnt;
      if (!run) begin
        st <= ENG_IDLE; wr_n <= 1'b1; rd_n <= 1'b1;
      end else if (beat_start) begin
        st      <= ENG_ACT;
        act_cnt <= act_m1;
        remain  <= remain - 1'b1;
        is_rd   <= rd_dir;
        if (rd_dir) rd_n <= 1'b0;
        else begin
          wr_n <= 1'b0;
          dout <= wide ? fifo_peek : {8'h00, fifo_peek[7:0]};
        end
      end else if (beat_end) begin
        st <= ENG_REST; rest_cnt <= rest_m1; wr_n <= 1'b1; rd_n <= 1'b1;
      end else if (tick) begin
        case (st)
          ENG_ACT:  act_cnt <= act_cnt - 1'b1;
          ENG_REST: if (rest_cnt == '0) st <= ENG_IDLE;
                    else rest_cnt <= rest_cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r12_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (st == ENG_IDLE && wr_n && rd_n));
  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_ACT && $past(st == ENG_ACT)) |-> $stable(dout));
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/pdisp_bus_engine.sv
module pdisp_bus_engine
  import pdisp_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter logic [15:0] VER_MAJOR  = 16'd2,
  parameter logic [15:0] VER_MINOR  = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [1:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_cs_n,
  output logic        bus_dc,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_oe,
  output logic [15:0] bus_dout,
  input  logic [15:0] bus_din
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam int CNT_W = 18;
  localparam int NW = CNT_W + 1;

  // timing/transfer register
  logic [CNT_W-1:0] cyc_m1;
  logic             dc_sel, cs_bit;
  logic [3:0]       act_m1;
  logic [5:0]       rest_m1;
  // control register
  logic             en, srst, wr_hold, rd_dir;
  // format register
  logic [4:0]       width_m1, beats_m1;
  logic [2:0]       div_m1;
  id_state_e        id_st;

  logic          tick, run, wide, cs_start, self_rst, eng_flush, drained;
  logic          wr_timing, wr_ctrl, wr_format, wr_ident, wr_port, rd_port, rd_ident;
  logic [2:0]    hsz, host_push_n, host_pop_n, eng_pop_n, eng_push_n, f_push_n, f_pop_n;
  logic [15:0]   eng_push_data;
  logic [31:0]   f_push_data, f_peek;
  logic [CW-1:0] f_cnt, f_space;
  logic          eng_busy, beat_start, beat_end;

  assign wr_timing = reg_wr && reg_addr == OFS_TIMING;
  assign wr_ctrl   = reg_wr && reg_addr == OFS_CTRL;
  assign wr_format = reg_wr && reg_addr == OFS_FORMAT;
  assign wr_ident  = reg_wr && reg_addr == OFS_IDENT;
  assign wr_port   = reg_wr && reg_addr == OFS_PORT && !rd_dir;
  assign rd_port   = reg_rd && reg_addr == OFS_PORT && rd_dir;
  assign rd_ident  = reg_rd && reg_addr == OFS_IDENT;

  assign wide      = (width_m1 == 5'd15);
  assign run       = en && !cs_bit;
  assign cs_start  = wr_timing && !reg_wdata[30] && cs_bit;
  assign self_rst  = rest_too_short(rest_m1);
  assign eng_flush = srst || self_rst;
  assign drained   = (f_cnt == '0) && !eng_busy;

  assign hsz         = size_bytes(reg_size);
  assign f_space     = CW'(FIFO_DEPTH) - f_cnt;
  assign host_push_n = (wr_port && f_space >= CW'(hsz)) ? hsz : 3'd0;
  assign host_pop_n  = !rd_port ? 3'd0 : (f_cnt >= CW'(hsz)) ? hsz : f_cnt[2:0];
  assign f_push_n    = rd_dir ? eng_push_n : host_push_n;
  assign f_push_data = rd_dir ? {16'h0000, eng_push_data} : reg_wdata;
  assign f_pop_n     = rd_dir ? host_pop_n : eng_pop_n;

  assign bus_cs_n = cs_bit || !en;
  assign bus_dc   = dc_sel;
  assign bus_oe   = !rd_dir && !bus_cs_n;

  pdisp_tick_div #(.DW(3)) u_div (
    .clk(clk), .rst_n(rst_n), .div_m1(div_m1), .tick(tick)
  );

  pdisp_byte_fifo #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(eng_flush),
    .push_n(f_push_n), .push_data(f_push_data),
    .pop_n(f_pop_n), .peek(f_peek), .count(f_cnt)
  );

  pdisp_beat_engine #(.DEPTH(FIFO_DEPTH), .CW(CW), .NW(NW)) u_eng (
    .clk(clk), .rst_n(rst_n), .flush(eng_flush), .tick(tick), .run(run),
    .load(cs_start), .load_cnt(NW'(reg_wdata[CNT_W-1:0]) + 1'b1),
    .rd_dir(rd_dir), .wr_allow(!wr_hold), .wide(wide),
    .act_m1(act_m1), .rest_m1(rest_m1),
    .fifo_cnt(f_cnt), .fifo_peek(f_peek[15:0]), .bus_din(bus_din),
    .pop_n(eng_pop_n), .push_n(eng_push_n), .push_data(eng_push_data),
    .wr_n(bus_wr_n), .rd_n(bus_rd_n), .dout(bus_dout),
    .busy(eng_busy), .beat_start(beat_start), .beat_end(beat_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_m1 <= '0; dc_sel <= 1'b0; act_m1 <= '0; rest_m1 <= 6'd3; cs_bit <= 1'b1;
      en <= 1'b0; srst <= 1'b0; wr_hold <= 1'b1; rd_dir <= 1'b0;
      width_m1 <= 5'd7; beats_m1 <= 5'd3; div_m1 <= '0;
      id_st <= ID_VER;
    end else begin
      if (wr_timing) begin
        cyc_m1  <= reg_wdata[17:0];
        dc_sel  <= reg_wdata[18];
        act_m1  <= reg_wdata[23:20];
        rest_m1 <= reg_wdata[29:24];
        cs_bit  <= reg_wdata[30];
      end
      if (wr_ctrl) begin
        en      <= reg_wdata[0];
        srst    <= reg_wdata[1];
        wr_hold <= reg_wdata[4];
        rd_dir  <= reg_wdata[5];
      end
      if (wr_format) begin
        width_m1 <= reg_wdata[4:0];
        beats_m1 <= reg_wdata[9:5];
        div_m1   <= reg_wdata[12:10];
      end
      if (wr_ident && reg_wdata == '0) id_st <= ID_FIRST;
      else if (rd_ident) begin
        case (id_st)
          ID_FIRST:  id_st <= ID_SECOND;
          ID_SECOND: id_st <= ID_VER;
          default:   id_st <= ID_VER;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFS_IDENT: reg_rdata <= (id_st == ID_FIRST) ? ID_PAT_A :
                                (id_st == ID_SECOND) ? ID_PAT_B : {VER_MAJOR, VER_MINOR};
        OFS_TIMING: reg_rdata <= {1'b0, cs_bit, rest_m1, act_m1, 1'b0, dc_sel, cyc_m1};
        OFS_CTRL:   reg_rdata <= {26'd0, rd_dir, wr_hold, drained, 1'b0, srst, en};
        OFS_FORMAT: reg_rdata <= {19'd0, div_m1, beats_m1, width_m1};
        OFS_PORT:   reg_rdata <= f_peek & byte_mask(host_pop_n);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R9: a strobe only falls while chip select was already active
  a_r9_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !$past(bus_cs_n));
  // R2: the armed ident register answers with the first pattern
  a_r2_ident_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_IDENT && id_st == ID_FIRST) |=> reg_rdata == ID_PAT_A);
  // R13: no write strobe in the read direction
  a_r13_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir && $past(rd_dir)) |-> bus_wr_n);
  // R12: a short rest value empties the buffer
  a_r12_self_reset: assert property (@(posedge clk) disable iff (!rst_n)
    self_rst |=> f_cnt == '0);

endmodule

// File: tb/tb_pdisp_bus_engine.sv
`timescale 1ns/1ps
module tb_pdisp_bus_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [1:0]  reg_size = 2'd2;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_oe;
  logic [15:0] bus_dout, bus_din = '0;

  int total = 0, bad = 0;
  bit done = 0;

  pdisp_bus_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  always #2.5 clk = ~clk;

  // ---- bus monitor, sampling on falling clock edges ----
  int cyc = 0, nwf = 0, nwr = 0, nrf = 0, nrr = 0, oe_seen = 0;
  int wf_t[64], wr_t[64], rf_t[64], rr_t[64];
  logic [15:0] wf_d[64];
  logic wf_dc[64], wf_cs[64];
  logic pw = 1'b1, pr = 1'b1;

  function automatic logic [15:0] rd_pat(input int k);
    return 16'hC3A0 ^ (16'(k) * 16'h1111);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pw && !bus_wr_n && nwf < 64) begin
      wf_t[nwf] = cyc; wf_d[nwf] = bus_dout; wf_dc[nwf] = bus_dc; wf_cs[nwf] = bus_cs_n; nwf++;
    end
    if (!pw && bus_wr_n && nwr < 64) begin wr_t[nwr] = cyc; nwr++; end
    if (pr && !bus_rd_n && nrf < 64) begin rf_t[nrf] = cyc; bus_din = rd_pat(nrf); nrf++; end
    if (!pr && bus_rd_n && nrr < 64) begin rr_t[nrr] = cyc; nrr++; end
    if (bus_oe) oe_seen++;
    pw = bus_wr_n; pr = bus_rd_n;
  end

  task automatic mon_clear();
    nwf = 0; nwr = 0; nrf = 0; nrr = 0; oe_seen = 0;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_timing(input bit cs, input int rest, input int act,
                                             input bit dc, input int cm1);
    return {1'b0, cs, 6'(rest), 4'(act), 1'b0, dc, 18'(cm1)};
  endfunction

  function automatic logic [31:0] mk_format(input bit wide, input int div);
    return {19'd0, 3'(div), wide ? 5'd1 : 5'd3, wide ? 5'd15 : 5'd7};
  endfunction

  logic [7:0] eb[16];

  task automatic wait_drained();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h08, 2'd2, v);
      if (v[3]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // fill the FIFO with n random bytes using mixed access sizes (R6)
  task automatic fill(input int n);
    int k = 0;
    while (k < n) begin
      int sz = int'($urandom % 3);
      int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      logic [31:0] d = $urandom;
      if (nb > n - k) begin sz = 0; nb = 1; end
      for (int i = 0; i < nb; i++) eb[k + i] = d[8*i +: 8];
      wr(5'h10, 2'(sz), d);
      k += nb;
    end
  endtask

  task automatic check_beats(input int n, input bit wide, input int a, input int r,
                             input int d, input bit dc);
    chk(nwf == n, "R7 beat count", nwf, n);
    for (int j = 0; j < nwf && j < n; j++) begin
      logic [15:0] e = wide ? {eb[2*j+1], eb[2*j]} : {8'h00, eb[j]};
      chk(wf_d[j] == e, "R5/R6 beat data", wf_d[j], e);
      chk(wr_t[j] - wf_t[j] == (a + 1) * (d + 1), "R3 strobe low width",
          wr_t[j] - wf_t[j], (a + 1) * (d + 1));
      chk(wf_dc[j] == dc, "R8 dc line", wf_dc[j], dc);
      chk(wf_cs[j] == 1'b0, "R9 cs active at strobe", wf_cs[j], 0);
      if (j > 0)
        chk(wf_t[j] - wr_t[j-1] == (r + 1) * (d + 1), "R4 strobe high gap",
            wf_t[j] - wr_t[j-1], (r + 1) * (d + 1));
    end
  endtask

  task automatic run_write(input bit wide, input int a, input int r, input int d,
                           input bit dc, input int nb, input bit rand_fill);
    int bpb = wide ? 2 : 1;
    wr(5'h0C, 2'd2, mk_format(wide, d));
    wr(5'h04, 2'd2, mk_timing(1, r, a, dc, nb - 1));
    if (rand_fill) fill(nb * bpb);
    mon_clear();
    wr(5'h04, 2'd2, mk_timing(0, r, a, dc, nb - 1));
    wait_drained();
    check_beats(nb, wide, a, r, d, dc);
    wr(5'h04, 2'd2, mk_timing(1, r, a, dc, nb - 1));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 idle pins", {bus_cs_n, bus_wr_n, bus_rd_n}, 3'b111);
    rd(5'h04, 2'd2, v); chk(v == 32'h4300_0000, "R1 timing reset", v, 32'h4300_0000);
    rd(5'h08, 2'd2, v); chk(v == 32'h0000_0018, "R1/R10 control reset", v, 32'h18);
    rd(5'h0C, 2'd2, v); chk(v == 32'h0000_0067, "R1 format reset", v, 32'h67);

    // R2 ident sequence
    wr(5'h00, 2'd2, 32'h0);
    rd(5'h00, 2'd2, v); chk(v == 32'h5555_5555, "R2 first pattern", v, 32'h55555555);
    rd(5'h00, 2'd2, v); chk(v == 32'hAAAA_AAAA, "R2 second pattern", v, 32'hAAAAAAAA);
    rd(5'h00, 2'd2, v); chk(v == 32'h0002_0001, "R2 version word", v, 32'h00020001);

    // directed 16-bit write with mixed host sizes (R5, R6)
    wr(5'h08, 2'd2, 32'h01);
    wr(5'h0C, 2'd2, mk_format(1, 1));
    wr(5'h04, 2'd2, mk_timing(1, 2, 3, 1, 3));
    wr(5'h10, 2'd2, 32'h1122_3344);
    wr(5'h10, 2'd1, 32'h0000_5566);
    wr(5'h10, 2'd0, 32'h0000_0077);
    wr(5'h10, 2'd0, 32'h0000_0088);
    eb[0] = 8'h44; eb[1] = 8'h33; eb[2] = 8'h22; eb[3] = 8'h11;
    eb[4] = 8'h66; eb[5] = 8'h55; eb[6] = 8'h77; eb[7] = 8'h88;
    run_write(1, 3, 2, 1, 1, 4, 0);

    // random formats and timings
    for (int it = 0; it < 8; it++) begin
      bit wide = 1'($urandom);
      int d = int'($urandom % 4);
      int a = int'($urandom % 4);
      int r = 2 + int'($urandom % 4);
      bit dc = 1'($urandom);
      int nb = 1 + int'($urandom % (wide ? 8 : 16));
      run_write(wide, a, r, d, dc, nb, 1);
    end
    // boundary: widest active and divider
    run_write(0, 15, 2, 7, 0, 2, 1);

    // R7 stop by itself with bytes left, R10 not drained
    wr(5'h0C, 2'd2, mk_format(0, 0));
    wr(5'h04, 2'd2, mk_timing(1, 2, 0, 1, 4));
    fill(16);
    mon_clear();
    wr(5'h04, 2'd2, mk_timing(0, 2, 0, 1, 4));
    repeat (200) @(negedge clk);
    chk(nwf == 5, "R7 stops after count", nwf, 5);
    rd(5'h08, 2'd2, v); chk(v[3] == 1'b0, "R10 not drained with leftovers", v[3], 0);
    wr(5'h04, 2'd2, mk_timing(1, 2, 0, 1, 4));

    // R12 self reset on short rest value flushes the FIFO
    wr(5'h04, 2'd2, mk_timing(1, 1, 0, 1, 0));
    wr(5'h04, 2'd2, mk_timing(1, 3, 0, 1, 0));
    rd(5'h08, 2'd2, v); chk(v[3] == 1'b1, "R12 self reset empties FIFO", v[3], 1);
    mon_clear();
    wr(5'h04, 2'd2, mk_timing(0, 3, 0, 1, 0));
    repeat (100) @(negedge clk);
    chk(nwf == 0, "R12 flushed bytes not sent", nwf, 0);
    wr(5'h04, 2'd2, mk_timing(1, 3, 0, 1, 0));

    // R12 soft reset
    fill(3);
    wr(5'h08, 2'd2, 32'h03);
    wr(5'h08, 2'd2, 32'h01);
    rd(5'h08, 2'd2, v); chk(v[3] == 1'b1, "R12 soft reset empties FIFO", v[3], 1);

    // R13 write hold bit blocks strobes until cleared
    wr(5'h08, 2'd2, 32'h11);
    fill(1);
    mon_clear();
    wr(5'h04, 2'd2, mk_timing(0, 2, 0, 0, 0));
    repeat (100) @(negedge clk);
    chk(nwf == 0, "R13 write hold blocks strobe", nwf, 0);
    wr(5'h08, 2'd2, 32'h01);
    repeat (50) @(negedge clk);
    chk(nwf == 1, "R13 strobe after hold release", nwf, 1);
    chk(wf_d[0] == {8'h00, eb[0]}, "R13 held byte sent", wf_d[0], eb[0]);
    wr(5'h04, 2'd2, mk_timing(1, 2, 0, 0, 0));

    // R9 chip select gated by enable
    wr(5'h08, 2'd2, 32'h00);
    wr(5'h04, 2'd2, mk_timing(0, 2, 0, 0, 0));
    @(negedge clk);
    chk(bus_cs_n == 1'b1, "R9 cs inactive when disabled", bus_cs_n, 1);
    wr(5'h08, 2'd2, 32'h01);
    @(negedge clk);
    chk(bus_cs_n == 1'b0, "R9 cs active when enabled", bus_cs_n, 0);
    wr(5'h04, 2'd2, mk_timing(1, 2, 0, 0, 0));

    // R11 read direction, 16-bit beats
    wr(5'h08, 2'd2, 32'h31);
    wr(5'h0C, 2'd2, mk_format(1, 0));
    wr(5'h04, 2'd2, mk_timing(1, 2, 1, 1, 3));
    mon_clear();
    wr(5'h04, 2'd2, mk_timing(0, 2, 1, 1, 3));
    repeat (100) @(negedge clk);
    chk(nrf == 4, "R11 read strobe count", nrf, 4);
    chk(nwf == 0 && oe_seen == 0, "R13 no drive while reading", nwf + oe_seen, 0);
    for (int j = 0; j < nrf && j < 4; j++)
      chk(rr_t[j] - rf_t[j] == 2, "R11 read strobe width", rr_t[j] - rf_t[j], 2);
    rd(5'h10, 2'd2, v);
    chk(v == {rd_pat(1), rd_pat(0)}, "R11 read word", v, {rd_pat(1), rd_pat(0)});
    rd(5'h10, 2'd1, v);
    chk(v == {16'h0, rd_pat(2)}, "R11 read half", v, rd_pat(2));
    rd(5'h10, 2'd0, v);
    chk(v == {24'h0, rd_pat(3)[7:0]}, "R11 read byte low", v, rd_pat(3)[7:0]);
    rd(5'h10, 2'd0, v);
    chk(v == {24'h0, rd_pat(3)[15:8]}, "R11 read byte high", v, rd_pat(3)[15:8]);
    rd(5'h10, 2'd2, v);
    chk(v == 32'h0, "R11 empty read is zero", v, 0);
    rd(5'h08, 2'd2, v); chk(v[3] == 1'b1, "R10 drained after reads", v[3], 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule